// File: doc/BRIEF.md
# Per-Tributary Line Parity Generator and Checker

This block produces and verifies the line-level BIP-8 parity bytes of a byte-interleaved STS-N style frame that passes it one byte per clock. Each byte arrives with its row (1 to 9) and global column (1 to 90·N), together with a start-of-frame marker and a byte-valid strobe. The frame is split into N tributaries, and each one keeps its own running even parity over the bytes that the line coverage rules include.

On the transmit side, the block runs the unscrambled outgoing stream through with one register of delay. At each tributary's parity slot it replaces the byte with the parity that tributary gathered over the previous frame. On the receive side, it accumulates the same parity over the descrambled incoming stream. In the next frame it compares that parity with the byte carried in the parity slot and adds the number of differing bits to a saturating error counter.

Each direction keeps two N×8 arrays. One holds the partial parities of the frame in progress. The other holds the finished values of the last complete frame.

Top module: `line_bip_engine`

## Requirements
- R1: A byte at global column c belongs to tributary (c−1) mod N, and its tributary column is ((c−1) div N)+1.
- R2: Bytes in rows 1–3 at tributary columns 1–3 are left out of every parity.
- R3: Every other byte is folded into its tributary's parity: rows 1–3 at tributary columns 4–90, and all columns 1–90 in rows 4–9. This includes payload bytes whatever their content.
- R4: Any transmit byte that is not replaced appears unchanged on `tx_dout` one clock after it is presented.
- R5: Once a frame has completed, the transmit byte at row 5, tributary column 1 is replaced one clock later by the even BIP-8 of that tributary's covered output bytes of the previous frame. Those output bytes include the parity byte that was inserted earlier.
- R6: After reset, `tx_dout` and `err_count` are 0. No byte is replaced and no error is counted until a frame that began with `sof` has reached row 9, column 90·N.
- R7: At each receive parity slot (row 5, tributary column 1) after the first complete frame, `err_count` grows one clock later by the popcount of (stored receive parity XOR received byte).
- R8: `err_clr` sets `err_count` to 0 on the next clock. If it falls in the same cycle as a counted mismatch, the clear wins.
- R9: `err_count` saturates at 2^ERR_W−1 and stays there until it is cleared.
- R10: A cycle with `in_valid` low changes no parity and no error count, and it still passes `tx_din` to `tx_dout`.
- R11: Accumulation starts at a valid byte with `sof` high. When row 9, column 90·N arrives, the partial parities, including that byte, move to the stored arrays and the partial arrays restart from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A byte is present on both data inputs this cycle |
| sof | input | 1 | Marks row 1, column 1 of a frame |
| row | input | 4 | Row of the current byte, 1..9 |
| col | input | COL_W | Global column of the current byte, 1..90·N |
| tx_din | input | 8 | Unscrambled transmit byte |
| tx_dout | output | 8 | Transmit byte with parity inserted, one clock later |
| rx_din | input | 8 | Descrambled receive byte |
| err_clr | input | 1 | Synchronous clear of the error counter |
| err_count | output | ERR_W | Saturating count of receive parity bit errors |

## Verification
Two events can land in the same cycle and interact: the clear of the error counter and the counting of a receive parity mismatch. The bench raises `err_clr` exactly on a parity slot whose received byte differs from the stored parity in every bit. It expects a count of zero on the next clock, not eight. The saturation limit also meets new mismatches. In later frames every parity byte is fully corrupted, so the counter is driven past its ceiling, and the bench expects it to stay pinned there. Idle cycles that carry parity-slot positions and junk data are mixed into every frame, to show that they neither change the count nor disturb the parities.

// File: rtl/line_bip_pkg.sv
package line_bip_pkg;

   localparam int ROWS_PER_FRAME = 9;
   localparam int COLS_PER_TRIB  = 90;
   localparam int OH_ROWS        = 3;
   localparam int OH_COLS        = 3;
   localparam int SLOT_ROW       = 5;

   function automatic logic [3:0] popcount8(input logic [7:0] v);
      logic [3:0] n;
      n = 4'd0;
      for (int i = 0; i < 8; i++) n = n + {3'd0, v[i]};
      return n;
   endfunction

endpackage

// File: rtl/bip_pos_decode.sv
module bip_pos_decode #(
   parameter int N_TRIB = 12,
   parameter int COL_W  = 11,
   parameter int TRIB_W = 4
) (
   input  logic [3:0]        row,
   input  logic [COL_W-1:0]  col,
   output logic [TRIB_W-1:0] trib,
   output logic              covered,
   output logic              b2_slot,
   output logic              last_byte
);
   import line_bip_pkg::*;

   localparam int LAST_COL = COLS_PER_TRIB * N_TRIB;

   logic [COL_W-1:0] col_m1;
   logic [COL_W-1:0] tcol;

   always_comb begin
      col_m1    = col - COL_W'(1);
      trib      = TRIB_W'(col_m1 % COL_W'(N_TRIB));
      tcol      = (col_m1 / COL_W'(N_TRIB)) + COL_W'(1);
      covered   = !((row <= 4'(OH_ROWS)) && (tcol <= COL_W'(OH_COLS)));
      b2_slot   = (row == 4'(SLOT_ROW)) && (tcol == COL_W'(1));
      last_byte = (row == 4'(ROWS_PER_FRAME)) && (col == COL_W'(LAST_COL));
   end

endmodule

// File: rtl/bip_accum_bank.sv
module bip_accum_bank #(
   parameter int N_TRIB = 12,
   parameter int TRIB_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_en,
   input  logic              frame_end,
   input  logic [TRIB_W-1:0] trib,
   input  logic [7:0]        data,
   output logic [7:0]        stored_sel
);
   logic [7:0] partial [N_TRIB];
   logic [7:0] stored  [N_TRIB];

   for (genvar t = 0; t < N_TRIB; t++) begin : g_trib
      logic       hit;
      logic [7:0] nxt;
      always_comb begin
         hit = acc_en && (trib == TRIB_W'(t));
         nxt = partial[t] ^ (hit ? data : 8'h00);
      end
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            partial[t] <= 8'h00;
            stored[t]  <= 8'h00;
         end else if (frame_end) begin
            stored[t]  <= nxt;
            partial[t] <= 8'h00;
         end else begin
            partial[t] <= nxt;
         end
      end
   end

   always_comb begin
      stored_sel = 8'h00;
      for (int t = 0; t < N_TRIB; t++)
         if (trib == TRIB_W'(t)) stored_sel = stored[t];
   end

endmodule

// File: rtl/bip_err_counter.sv
module bip_err_counter #(
   parameter int ERR_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             add_en,
   input  logic [7:0]       calc,
   input  logic [7:0]       rcv,
   output logic [ERR_W-1:0] count
);
   import line_bip_pkg::*;

   localparam logic [ERR_W:0] SAT = {1'b0, {ERR_W{1'b1}}};

   logic [ERR_W:0] sum;

   always_comb sum = {1'b0, count} + (ERR_W+1)'(popcount8(calc ^ rcv));

   always_ff @(posedge clk) begin
      if (!rst_n || clr)  count <= '0;
      else if (add_en)    count <= (sum > SAT) ? SAT[ERR_W-1:0] : sum[ERR_W-1:0];
   end

endmodule

// File: rtl/line_bip_engine.sv
module line_bip_engine #(
   parameter int N_TRIB = 12,
   parameter int ERR_W  = 16,
   localparam int LAST_COL = 90 * N_TRIB,
   localparam int COL_W    = $clog2(LAST_COL + 1),
   localparam int TRIB_W   = (N_TRIB > 1) ? $clog2(N_TRIB) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic             sof,
   input  logic [3:0]       row,
   input  logic [COL_W-1:0] col,
   input  logic [7:0]       tx_din,
   output logic [7:0]       tx_dout,
   input  logic [7:0]       rx_din,
   input  logic             err_clr,
   output logic [ERR_W-1:0] err_count
);
   if (N_TRIB < 1) begin : g_bad_trib
      $error("line_bip_engine: N_TRIB must be at least 1");
   end
   if (ERR_W < 4) begin : g_bad_errw
      $error("line_bip_engine: ERR_W must be at least 4");
   end

   logic [TRIB_W-1:0] slot_trib;
   logic              slot_cov;
   logic              slot_b2;
   logic              slot_last;
   logic              frame_on;
   logic              parity_ready;
   logic              take;
   logic [7:0]        tx_byte;
   logic [7:0]        tx_stored;
   logic [7:0]        rx_stored;

   bip_pos_decode #(.N_TRIB(N_TRIB), .COL_W(COL_W), .TRIB_W(TRIB_W)) i_decode (
      .row       (row),
      .col       (col),
      .trib      (slot_trib),
      .covered   (slot_cov),
      .b2_slot   (slot_b2),
      .last_byte (slot_last)
   );

   always_comb begin
      take    = in_valid && (sof || frame_on);
      tx_byte = (in_valid && parity_ready && slot_b2) ? tx_stored : tx_din;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         frame_on     <= 1'b0;
         parity_ready <= 1'b0;
         tx_dout      <= 8'h00;
      end else begin
         if (in_valid && sof)    frame_on     <= 1'b1;
         if (take && slot_last)  parity_ready <= 1'b1;
         tx_dout <= tx_byte;
      end
   end

   bip_accum_bank #(.N_TRIB(N_TRIB), .TRIB_W(TRIB_W)) i_tx_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .acc_en     (take && slot_cov),
      .frame_end  (take && slot_last),
      .trib       (slot_trib),
      .data       (tx_byte),
      .stored_sel (tx_stored)
   );

   bip_accum_bank #(.N_TRIB(N_TRIB), .TRIB_W(TRIB_W)) i_rx_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .acc_en     (take && slot_cov),
      .frame_end  (take && slot_last),
      .trib       (slot_trib),
      .data       (rx_din),
      .stored_sel (rx_stored)
   );

   bip_err_counter #(.ERR_W(ERR_W)) i_err (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (err_clr),
      .add_en (in_valid && parity_ready && slot_b2),
      .calc   (rx_stored),
      .rcv    (rx_din),
      .count  (err_count)
   );

endmodule

// File: rtl/line_bip_checker.sv
module line_bip_checker #(
   parameter int ERR_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [7:0]       tx_din,
   input  logic [7:0]       tx_dout,
   input  logic             err_clr,
   input  logic [ERR_W-1:0] err_count,
   input  logic             ready,
   input  logic             b2_slot
);
   localparam logic [ERR_W-1:0] MAXV = {ERR_W{1'b1}};

   p_pass_through_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(in_valid && ready && b2_slot) |=> tx_dout == $past(tx_din));

   p_ready_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
      ready |=> ready);

   p_no_count_early_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!ready && !err_clr) |=> $stable(err_count));

   p_idle_no_count_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_valid && !err_clr) |=> $stable(err_count));

   p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      err_clr |=> err_count == '0);

   p_step_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !err_clr |=> (err_count >= $past(err_count)) &&
                   ((err_count - $past(err_count)) <= ERR_W'(8)));

   p_sat_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (err_count == MAXV && !err_clr) |=> err_count == MAXV);

endmodule

bind line_bip_engine line_bip_checker #(.ERR_W(ERR_W)) i_line_bip_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .tx_din    (tx_din),
   .tx_dout   (tx_dout),
   .err_clr   (err_clr),
   .err_count (err_count),
   .ready     (parity_ready),
   .b2_slot   (slot_b2)
);

// File: tb/test_line_bip_engine.sv
module test_line_bip_engine;
   localparam int N  = 3;
   localparam int EW = 6;
   localparam int LASTC = 90 * N;
   localparam int CW = $clog2(LASTC + 1);
   localparam int MAXE = (1 << EW) - 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0, sof = 1'b0, err_clr = 1'b0;
   logic [3:0] row = 4'd1;
   logic [CW-1:0] col = CW'(1);
   logic [7:0] tx_din = 8'h00, rx_din = 8'h00;
   logic [7:0] tx_dout;
   logic [EW-1:0] err_count;

   int vecs = 0, errs = 0;

   // bench reference state
   logic [7:0] m_txp [N];
   logic [7:0] m_txs [N];
   logic [7:0] m_rxp [N];
   logic [7:0] m_rxs [N];
   bit m_on = 0, m_ready = 0;
   int m_err = 0;

   always #2.5 clk = ~clk;

   line_bip_engine #(.N_TRIB(N), .ERR_W(EW)) i_line_bip_engine (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .sof(sof), .row(row),
      .col(col), .tx_din(tx_din), .tx_dout(tx_dout), .rx_din(rx_din),
      .err_clr(err_clr), .err_count(err_count));

   function automatic int pop8(input logic [7:0] v);
      int n = 0;
      for (int i = 0; i < 8; i++) n += v[i];
      return n;
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      vecs++;
      if (!ok) begin
         errs++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // one cycle: drive, update the reference, compare after the edge
   task automatic step(input bit v, input bit s, input int r, input int c,
                       input logic [7:0] tx, input logic [7:0] rx, input bit clr);
      int t, tc;
      bit cov, b2, tk;
      logic [7:0] exp_out;
      string treq, ereq;
      @(negedge clk);
      in_valid = v; sof = s; row = 4'(r); col = CW'(c);
      tx_din = tx; rx_din = rx; err_clr = clr;
      t  = (c - 1) % N;             // R1 mapping
      tc = (c - 1) / N + 1;
      cov = !(r <= 3 && tc <= 3);   // R2 / R3 coverage
      b2  = (r == 5 && tc == 1);
      tk  = v && (s || m_on);
      exp_out = (v && m_ready && b2) ? m_txs[t] : tx;
      treq = !v ? "R10" : ((m_ready && b2) ? "R5" : "R4");
      if (clr) m_err = 0;
      else if (v && m_ready && b2) begin
         m_err += pop8(m_rxs[t] ^ rx);
         if (m_err > MAXE) m_err = MAXE;
      end
      ereq = clr ? "R8" : (m_err == MAXE ? "R9" : (!m_ready ? "R6" : (!v ? "R10" : "R7")));
      if (tk && cov) begin
         m_txp[t] ^= exp_out;
         m_rxp[t] ^= rx;
      end
      if (v && s) m_on = 1;
      if (tk && r == 9 && c == LASTC) begin   // R11 frame hand-over
         for (int k = 0; k < N; k++) begin
            m_txs[k] = m_txp[k]; m_rxs[k] = m_rxp[k];
            m_txp[k] = 8'h00;    m_rxp[k] = 8'h00;
         end
         m_ready = 1;
      end
      @(posedge clk); #1;
      check(tx_dout == exp_out, treq, tx_dout, exp_out);
      check(int'(err_count) == m_err, ereq, err_count, m_err);
   endtask

   task automatic idle();
      step(0, 0, 1 + $urandom_range(0, 8), 1 + $urandom_range(0, LASTC - 1),
           8'($urandom), 8'($urandom), 0);
   endtask

   // full frame; err_mode 0 clean, 1 random corruption, 2 all bits flipped
   task automatic frame(input bit with_sof, input int gap_pct, input int err_mode,
                        input int clr_col);
      for (int r = 1; r <= 9; r++)
         for (int c = 1; c <= LASTC; c++) begin
            logic [7:0] rx;
            int t;
            bit b2;
            t = (c - 1) % N;
            b2 = (r == 5 && ((c - 1) / N) == 0);
            if ($urandom_range(0, 99) < gap_pct) idle();
            rx = 8'($urandom);
            if (b2 && m_ready) begin
               rx = m_rxs[t];
               if (err_mode == 1 && $urandom_range(0, 1) == 1) rx ^= 8'($urandom);
               if (err_mode == 2) rx = ~m_rxs[t];
            end
            step(1, with_sof && r == 1 && c == 1, r, c, 8'($urandom), rx,
                 (r == 5 && c == clr_col));
         end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errs++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED_0A11));
      for (int k = 0; k < N; k++) begin
         m_txp[k] = 0; m_txs[k] = 0; m_rxp[k] = 0; m_rxs[k] = 0;
      end
      repeat (3) @(posedge clk);
      #1;
      check(tx_dout == 8'h00, "R6 reset tx", tx_dout, 0);
      check(err_count == '0, "R6 reset count", err_count, 0);
      @(negedge clk); rst_n = 1'b1;
      // R6: frame without sof must not arm the block
      frame(0, 5, 0, 0);
      // R11 / R5 / R1..R3: frames started with sof, random gaps
      frame(1, 10, 0, 0);
      frame(1, 10, 0, 0);
      frame(0, 20, 1, 0);                 // R7 random mismatches
      // R8: clear on a fully mismatching slot (tributary 0 slot at col 1)
      frame(0, 5, 2, 1);
      // R9: drive the counter past its ceiling
      frame(0, 5, 2, 0);
      frame(0, 5, 2, 0);
      frame(0, 5, 2, 0);
      check(int'(err_count) == MAXE, "R9 saturated", err_count, MAXE);
      step(0, 0, 1, 1, 8'h00, 8'h00, 1);  // R8 standalone clear
      frame(0, 0, 0, 0);
      check(err_count == '0, "R7 clean frame", err_count, 0);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
   end

endmodule